// File: doc/BRIEF.md
# Bus Address/Data Match Comparator

This block watches one bus cycle per clock and raises a trigger when that cycle meets a programmed condition. Two bus masters feed it, each with its own address, 16-bit data, direction and size signals. A select input decides which of the two is observed. The other master's signals then have no effect.

The comparator has three active modes. The exact mode needs the address to equal the low limit register, and it also needs the masked data to equal a reference value. The inside mode needs the address to lie between the low and high limits, with both limits included. The outside mode needs the address to lie strictly below the low limit or strictly above the high limit. The two range modes look at the address only.

Direction and access size can each be required to take a programmed value, and each of these qualifiers is switched on separately. A parameter builds an address-only variant, in which data never affects the result. The output is registered. A trigger consumer sees one pulse for each qualifying bus cycle.

Top module: `bus_match_cmp`

## Requirements
- R1: While `rst_n` is low, `match` is 0.
- R2: `match` is high in the clock after a qualifying bus cycle, and only then: one pulse per cycle in which the selected master's valid is high and every condition holds. `match` stays 0 after a cycle with valid low.
- R3: In a cycle where `enable` is 0, no match is produced for that cycle.
- R4: `src_sel` = 0 observes the `m0_*` signals and `src_sel` = 1 observes the `m1_*` signals. The unselected master has no effect on `match`.
- R5: `cfg_mode` = 0 (exact) matches when the address equals `cfg_addr_lo` and every participating data bit equals the corresponding bit of `cfg_data`.
- R6: Data bit i takes part only when `cfg_mask[i]` is 1. With an all-zero mask, the data compare always succeeds.
- R7: On a byte access (`byte` = 1) in exact mode, only one lane takes part. Address bit 0 = 0 selects data bits [7:0], and address bit 0 = 1 selects bits [15:8]. The other lane is ignored.
- R8: `cfg_mode` = 1 (inside) matches when `cfg_addr_lo` ≤ address ≤ `cfg_addr_hi`. Data does not matter in this mode.
- R9: `cfg_mode` = 2 (outside) matches when address < `cfg_addr_lo` or address > `cfg_addr_hi`. Data does not matter in this mode.
- R10: `cfg_mode` = 3 never matches.
- R11: When `cfg_rw_en` is 1, a match also needs the cycle's `write` to equal `cfg_rw_write`, where 1 means write. When `cfg_rw_en` is 0, direction has no effect.
- R12: When `cfg_sz_en` is 1, a match also needs the cycle's `byte` to equal `cfg_sz_byte`, where 1 means byte. When `cfg_sz_en` is 0, size has no effect.
- R13: With parameter `HAS_DATA` = 0, exact mode compares the address only, and data and mask have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Comparator enable |
| src_sel | input | 1 | 0 selects master 0, 1 selects master 1 |
| m0_valid | input | 1 | Master 0 bus cycle valid |
| m0_addr | input | ADDR_W | Master 0 address |
| m0_data | input | 16 | Master 0 data |
| m0_write | input | 1 | Master 0 direction, 1 = write |
| m0_byte | input | 1 | Master 0 size, 1 = byte |
| m1_valid | input | 1 | Master 1 bus cycle valid |
| m1_addr | input | ADDR_W | Master 1 address |
| m1_data | input | 16 | Master 1 data |
| m1_write | input | 1 | Master 1 direction, 1 = write |
| m1_byte | input | 1 | Master 1 size, 1 = byte |
| cfg_mode | input | 2 | 0 exact, 1 inside, 2 outside, 3 off |
| cfg_addr_lo | input | ADDR_W | Exact address, or lower range limit |
| cfg_addr_hi | input | ADDR_W | Upper range limit |
| cfg_data | input | 16 | Data reference |
| cfg_mask | input | 16 | Data mask, 1 = bit participates |
| cfg_rw_en | input | 1 | Enable direction qualifier |
| cfg_rw_write | input | 1 | Required direction, 1 = write |
| cfg_sz_en | input | 1 | Enable size qualifier |
| cfg_sz_byte | input | 1 | Required size, 1 = byte |
| match | output | 1 | Registered one-cycle match pulse |

## Verification
The hardest case to reach from the ports is a byte access where a data mismatch sits only in the lane that is not addressed. Such a cycle has to match, while the same mismatch in the addressed lane has to block the match. The stimulus reaches it by keeping the reference word fixed and flipping one lane at a time. It does this at an even exact address and again at an odd exact address.

The range boundaries are also covered. Addresses are placed at one below the low limit, at the low limit, at the high limit and at one above the high limit, in both range modes, with data deliberately wrong. An address-only instance runs on the same stimulus, so every exact-mode data mismatch also checks that data has no effect in that variant.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = DATA_W / 2;

  typedef enum logic [1:0] {
    CMP_EXACT   = 2'd0,
    CMP_INSIDE  = 2'd1,
    CMP_OUTSIDE = 2'd2,
    CMP_OFF     = 2'd3
  } cmp_mode_e;

  // Mask of the data bits that take part for a given access size and lane
  function automatic logic [DATA_W-1:0] lane_bits(input logic is_byte, input logic hi_lane);
    logic [DATA_W-1:0] m;
    if (!is_byte)     m = '1;
    else if (hi_lane) m = {{LANE_W{1'b1}}, {LANE_W{1'b0}}};
    else              m = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
    return m;
  endfunction

  // True when every selected bit of value equals the reference
  function automatic logic masked_equal(input logic [DATA_W-1:0] value,
                                        input logic [DATA_W-1:0] ref_val,
                                        input logic [DATA_W-1:0] sel);
    return ((value ^ ref_val) & sel) == '0;
  endfunction
endpackage

// File: rtl/bmc_bus_select.sv
module bmc_bus_select #(
  parameter int ADDR_W = 16
) (
  input  logic                      src_sel,
  input  logic                      m0_valid,
  input  logic [ADDR_W-1:0]         m0_addr,
  input  logic [bmc_pkg::DATA_W-1:0] m0_data,
  input  logic                      m0_write,
  input  logic                      m0_byte,
  input  logic                      m1_valid,
  input  logic [ADDR_W-1:0]         m1_addr,
  input  logic [bmc_pkg::DATA_W-1:0] m1_data,
  input  logic                      m1_write,
  input  logic                      m1_byte,
  output logic                      sel_valid,
  output logic [ADDR_W-1:0]         sel_addr,
  output logic [bmc_pkg::DATA_W-1:0] sel_data,
  output logic                      sel_write,
  output logic                      sel_byte
);
  always_comb begin
    if (src_sel) begin
      sel_valid = m1_valid;
      sel_addr  = m1_addr;
      sel_data  = m1_data;
      sel_write = m1_write;
      sel_byte  = m1_byte;
    end else begin
      sel_valid = m0_valid;
      sel_addr  = m0_addr;
      sel_data  = m0_data;
      sel_write = m0_write;
      sel_byte  = m0_byte;
    end
  end
endmodule

// File: rtl/bmc_addr_cmp.sv
module bmc_addr_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lim_lo,
  input  logic [ADDR_W-1:0] lim_hi,
  output logic              eq_hit,
  output logic              in_hit,
  output logic              out_hit
);
  logic below_lo;
  logic above_hi;

  assign eq_hit   = (addr == lim_lo);
  assign below_lo = (addr < lim_lo);
  assign above_hi = (addr > lim_hi);
  assign in_hit   = !below_lo && !above_hi;
  assign out_hit  = below_lo || above_hi;
endmodule

// File: rtl/bmc_data_cmp.sv
module bmc_data_cmp #(
  parameter bit HAS_DATA = 1'b1
) (
  input  logic [bmc_pkg::DATA_W-1:0] data,
  input  logic [bmc_pkg::DATA_W-1:0] ref_data,
  input  logic [bmc_pkg::DATA_W-1:0] mask,
  input  logic                       is_byte,
  input  logic                       hi_lane,
  output logic                       data_ok
);
  import bmc_pkg::*;
  logic [DATA_W-1:0] part_bits;
  logic              cmp_eq;

  assign part_bits = mask & lane_bits(is_byte, hi_lane);
  assign cmp_eq    = masked_equal(data, ref_data, part_bits);

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = cmp_eq;
    end else begin : g_addr_only
      assign data_ok = cmp_eq | 1'b1;
    end
  endgenerate
endmodule

// File: rtl/bmc_access_qual.sv
module bmc_access_qual (
  input  logic write,
  input  logic is_byte,
  input  logic rw_en,
  input  logic rw_write,
  input  logic sz_en,
  input  logic sz_byte,
  output logic acc_ok
);
  logic rw_ok;
  logic sz_ok;

  assign rw_ok  = !rw_en || (write == rw_write);
  assign sz_ok  = !sz_en || (is_byte == sz_byte);
  assign acc_ok = rw_ok && sz_ok;
endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp #(
  parameter int ADDR_W   = 16,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              src_sel,
  input  logic              m0_valid,
  input  logic [ADDR_W-1:0] m0_addr,
  input  logic [15:0]       m0_data,
  input  logic              m0_write,
  input  logic              m0_byte,
  input  logic              m1_valid,
  input  logic [ADDR_W-1:0] m1_addr,
  input  logic [15:0]       m1_data,
  input  logic              m1_write,
  input  logic              m1_byte,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_addr_lo,
  input  logic [ADDR_W-1:0] cfg_addr_hi,
  input  logic [15:0]       cfg_data,
  input  logic [15:0]       cfg_mask,
  input  logic              cfg_rw_en,
  input  logic              cfg_rw_write,
  input  logic              cfg_sz_en,
  input  logic              cfg_sz_byte,
  output logic              match
);
  import bmc_pkg::*;

  // Named internal events, visible to the bound checker
  logic              sel_valid;
  logic [ADDR_W-1:0] sel_addr;
  logic [15:0]       sel_data;
  logic              sel_write;
  logic              sel_byte;
  logic              eq_hit;
  logic              in_hit;
  logic              out_hit;
  logic              data_ok;
  logic              acc_ok;
  logic              mode_hit;
  logic              cycle_hit;
  cmp_mode_e         mode;

  assign mode = cmp_mode_e'(cfg_mode);

  bmc_bus_select #(.ADDR_W(ADDR_W)) u_sel (
    .src_sel  (src_sel),
    .m0_valid (m0_valid), .m0_addr(m0_addr), .m0_data(m0_data),
    .m0_write (m0_write), .m0_byte(m0_byte),
    .m1_valid (m1_valid), .m1_addr(m1_addr), .m1_data(m1_data),
    .m1_write (m1_write), .m1_byte(m1_byte),
    .sel_valid(sel_valid), .sel_addr(sel_addr), .sel_data(sel_data),
    .sel_write(sel_write), .sel_byte(sel_byte)
  );

  bmc_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .addr   (sel_addr),
    .lim_lo (cfg_addr_lo),
    .lim_hi (cfg_addr_hi),
    .eq_hit (eq_hit),
    .in_hit (in_hit),
    .out_hit(out_hit)
  );

  bmc_data_cmp #(.HAS_DATA(HAS_DATA)) u_data (
    .data    (sel_data),
    .ref_data(cfg_data),
    .mask    (cfg_mask),
    .is_byte (sel_byte),
    .hi_lane (sel_addr[0]),
    .data_ok (data_ok)
  );

  bmc_access_qual u_acc (
    .write   (sel_write),
    .is_byte (sel_byte),
    .rw_en   (cfg_rw_en),
    .rw_write(cfg_rw_write),
    .sz_en   (cfg_sz_en),
    .sz_byte (cfg_sz_byte),
    .acc_ok  (acc_ok)
  );

  always_comb begin
    unique case (mode)
      CMP_EXACT:   mode_hit = eq_hit && data_ok;
      CMP_INSIDE:  mode_hit = in_hit;
      CMP_OUTSIDE: mode_hit = out_hit;
      default:     mode_hit = 1'b0;
    endcase
  end

  assign cycle_hit = enable && sel_valid && acc_ok && mode_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match <= 1'b0;
    else        match <= cycle_hit;
  end
endmodule

// File: rtl/bmc_match_chk.sv
module bmc_match_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              sel_valid,
  input logic [ADDR_W-1:0] sel_addr,
  input logic              sel_write,
  input logic              sel_byte,
  input logic [1:0]        cfg_mode,
  input logic [ADDR_W-1:0] cfg_addr_lo,
  input logic [ADDR_W-1:0] cfg_addr_hi,
  input logic              cfg_rw_en,
  input logic              cfg_rw_write,
  input logic              cfg_sz_en,
  input logic              cfg_sz_byte,
  input logic              match
);
  p_valid_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(sel_valid));

  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(enable));

  p_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(cfg_mode) == 2'd1) |->
      ($past(sel_addr) >= $past(cfg_addr_lo) && $past(sel_addr) <= $past(cfg_addr_hi)));

  p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(cfg_mode) == 2'd2) |->
      ($past(sel_addr) < $past(cfg_addr_lo) || $past(sel_addr) > $past(cfg_addr_hi)));

  p_off_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(cfg_mode) != 2'd3);

  p_dir_qual_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(cfg_rw_en)) |-> $past(sel_write) == $past(cfg_rw_write));

  p_size_qual_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(cfg_sz_en)) |-> $past(sel_byte) == $past(cfg_sz_byte));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (match == 1'b0);
    end
  end
endmodule

bind bus_match_cmp bmc_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sel_valid(sel_valid),
  .sel_addr(sel_addr), .sel_write(sel_write), .sel_byte(sel_byte),
  .cfg_mode(cfg_mode), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
  .cfg_rw_en(cfg_rw_en), .cfg_rw_write(cfg_rw_write),
  .cfg_sz_en(cfg_sz_en), .cfg_sz_byte(cfg_sz_byte), .match(match)
);

// File: tb/bus_match_cmp_tb.sv
module bus_match_cmp_tb;
  localparam int AW = 16;

  typedef struct {
    logic  exp_full;
    logic  exp_ao;
    string tag;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0, src_sel = 0;
  logic m0_valid = 0, m0_write = 0, m0_byte = 0;
  logic m1_valid = 0, m1_write = 0, m1_byte = 0;
  logic [AW-1:0] m0_addr = '0, m1_addr = '0;
  logic [15:0] m0_data = '0, m1_data = '0;
  logic [1:0] cfg_mode = 2'd0;
  logic [AW-1:0] cfg_addr_lo = '0, cfg_addr_hi = '0;
  logic [15:0] cfg_data = '0, cfg_mask = '0;
  logic cfg_rw_en = 0, cfg_rw_write = 0, cfg_sz_en = 0, cfg_sz_byte = 0;
  logic match, match_ao;

  int n_tests = 0;
  int n_fail  = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  bus_match_cmp #(.ADDR_W(AW), .HAS_DATA(1'b1)) u_dut (
    .clk, .rst_n, .enable, .src_sel,
    .m0_valid, .m0_addr, .m0_data, .m0_write, .m0_byte,
    .m1_valid, .m1_addr, .m1_data, .m1_write, .m1_byte,
    .cfg_mode, .cfg_addr_lo, .cfg_addr_hi, .cfg_data, .cfg_mask,
    .cfg_rw_en, .cfg_rw_write, .cfg_sz_en, .cfg_sz_byte, .match(match)
  );

  bus_match_cmp #(.ADDR_W(AW), .HAS_DATA(1'b0)) u_ao (
    .clk, .rst_n, .enable, .src_sel,
    .m0_valid, .m0_addr, .m0_data, .m0_write, .m0_byte,
    .m1_valid, .m1_addr, .m1_data, .m1_write, .m1_byte,
    .cfg_mode, .cfg_addr_lo, .cfg_addr_hi, .cfg_data, .cfg_mask,
    .cfg_rw_en, .cfg_rw_write, .cfg_sz_en, .cfg_sz_byte, .match(match_ao)
  );

  // Reference model written bit by bit from the requirements
  function automatic logic model(input bit with_data);
    logic v, w, b;
    logic [AW-1:0] a;
    logic [15:0] d;
    bit ok;
    v = src_sel ? m1_valid : m0_valid;
    a = src_sel ? m1_addr  : m0_addr;
    d = src_sel ? m1_data  : m0_data;
    w = src_sel ? m1_write : m0_write;
    b = src_sel ? m1_byte  : m0_byte;
    if (!enable || !v) return 1'b0;
    if (cfg_rw_en && (w != cfg_rw_write)) return 1'b0;
    if (cfg_sz_en && (b != cfg_sz_byte)) return 1'b0;
    case (cfg_mode)
      2'd0: begin
        ok = (a == cfg_addr_lo);
        if (with_data) begin
          for (int i = 0; i < 16; i++) begin
            bit in_lane;
            in_lane = !b || (a[0] ? (i >= 8) : (i < 8));
            if (cfg_mask[i] && in_lane && (d[i] != cfg_data[i])) ok = 0;
          end
        end
        return ok;
      end
      2'd1: return (a >= cfg_addr_lo) && (a <= cfg_addr_hi);
      2'd2: return (a < cfg_addr_lo) || (a > cfg_addr_hi);
      default: return 1'b0;
    endcase
  endfunction

  // Driver: inputs already set at this negedge; record expectation, advance
  task automatic cyc(input string tag);
    item_t it;
    it.exp_full = model(1'b1);
    it.exp_ao   = model(1'b0);
    it.tag      = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic bus0(input logic v, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic w, input logic b);
    m0_valid = v; m0_addr = a; m0_data = d; m0_write = w; m0_byte = b;
  endtask

  // Monitor: compare one cycle after each recorded bus cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if (match !== it.exp_full) begin
          n_fail++;
          $display("FAIL %s: match=%b expected %b", it.tag, match, it.exp_full);
        end
        n_tests++;
        if (match_ao !== it.exp_ao) begin
          n_fail++;
          $display("FAIL %s (R13 address-only): match=%b expected %b", it.tag, match_ao, it.exp_ao);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (match !== 1'b0 || match_ao !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: match=%b expected 0", match);
    end
    rst_n = 1;
    @(negedge clk);

    enable = 1; cfg_mode = 2'd0; cfg_addr_lo = 16'h1000; cfg_addr_hi = 16'h1010;
    cfg_data = 16'hA55A; cfg_mask = 16'hFFFF;

    // R2 idle, single, back-to-back
    bus0(0, 16'h1000, 16'hA55A, 0, 0); cyc("R2 valid low");
    bus0(1, 16'h1000, 16'hA55A, 0, 0); cyc("R2 hit");
    cyc("R2 back-to-back hit");
    bus0(0, 16'h1000, 16'hA55A, 0, 0); cyc("R2 drop after hit");
    // R3
    enable = 0; bus0(1, 16'h1000, 16'hA55A, 0, 0); cyc("R3 disabled"); enable = 1;
    // R5
    bus0(1, 16'h1002, 16'hA55A, 0, 0); cyc("R5 address differs");
    bus0(1, 16'h1000, 16'hA55B, 0, 0); cyc("R5 data differs");
    // R6
    cfg_mask = 16'h00FF; bus0(1, 16'h1000, 16'h005A, 0, 0); cyc("R6 masked upper bits");
    bus0(1, 16'h1000, 16'hA55B, 0, 0); cyc("R6 unmasked bit differs");
    cfg_mask = 16'h0000; bus0(1, 16'h1000, 16'h1234, 0, 0); cyc("R6 zero mask");
    cfg_mask = 16'hFFFF;
    // R7 byte lanes
    bus0(1, 16'h1000, 16'h005A, 0, 1); cyc("R7 even byte, upper lane ignored");
    bus0(1, 16'h1000, 16'hA500, 0, 1); cyc("R7 even byte, lower lane differs");
    cfg_addr_lo = 16'h1001;
    bus0(1, 16'h1001, 16'hA500, 0, 1); cyc("R7 odd byte, lower lane ignored");
    bus0(1, 16'h1001, 16'h005A, 0, 1); cyc("R7 odd byte, upper lane differs");
    bus0(1, 16'h1001, 16'hA500, 0, 0); cyc("R7 word at odd address full compare");
    cfg_addr_lo = 16'h1000;
    // R4 source select
    bus0(0, 16'h0000, 16'h0000, 0, 0);
    m1_valid = 1; m1_addr = 16'h1000; m1_data = 16'hA55A;
    cyc("R4 master1 ignored when sel=0");
    src_sel = 1; cyc("R4 master1 observed");
    bus0(1, 16'h1000, 16'hA55A, 0, 0); m1_data = 16'h0000; cyc("R4 master0 ignored when sel=1");
    src_sel = 0; m1_valid = 0;
    // R8 inside, data wrong on purpose
    cfg_mode = 2'd1;
    bus0(1, 16'h0FFF, 16'h0000, 0, 0); cyc("R8 below low");
    bus0(1, 16'h1000, 16'h0000, 0, 0); cyc("R8 at low");
    bus0(1, 16'h1010, 16'h0000, 0, 0); cyc("R8 at high");
    bus0(1, 16'h1011, 16'h0000, 0, 0); cyc("R8 above high");
    // R9 outside
    cfg_mode = 2'd2;
    bus0(1, 16'h0FFF, 16'h0000, 0, 0); cyc("R9 below low");
    bus0(1, 16'h1000, 16'h0000, 0, 0); cyc("R9 at low");
    bus0(1, 16'h1010, 16'h0000, 0, 0); cyc("R9 at high");
    bus0(1, 16'h1011, 16'h0000, 0, 0); cyc("R9 above high");
    // R10
    cfg_mode = 2'd3; bus0(1, 16'h1000, 16'hA55A, 0, 0); cyc("R10 off mode");
    // R11
    cfg_mode = 2'd0; cfg_rw_en = 1; cfg_rw_write = 1;
    bus0(1, 16'h1000, 16'hA55A, 0, 0); cyc("R11 read rejected");
    bus0(1, 16'h1000, 16'hA55A, 1, 0); cyc("R11 write accepted");
    cfg_rw_en = 0; bus0(1, 16'h1000, 16'hA55A, 0, 0); cyc("R11 qualifier off");
    // R12
    cfg_sz_en = 1; cfg_sz_byte = 0; cfg_mode = 2'd1;
    bus0(1, 16'h1004, 16'h0000, 0, 1); cyc("R12 byte rejected");
    bus0(1, 16'h1004, 16'h0000, 0, 0); cyc("R12 word accepted");
    cfg_sz_byte = 1; bus0(1, 16'h1004, 16'h0000, 0, 1); cyc("R12 byte required");
    cfg_sz_en = 0;
    // R13 address-only instance with wrong data in exact mode
    cfg_mode = 2'd0; bus0(1, 16'h1000, 16'hFFFF, 0, 0); cyc("R13 data ignored");
    bus0(0, 16'h0000, 16'h0000, 0, 0); cyc("R2 final idle");

    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule